// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the receive side of an Ethernet MAC and rules on each incoming frame as soon as the frame's destination address and length are known. It sorts the destination into one of three classes:

- broadcast, when all 48 bits are ones;
- multicast, when the group bit is set;
- unicast, in all other cases.

It then applies the accept policy for that class and a maximum-length limit. The decision is returned one cycle later with its own valid pulse.

The policy state lives in a small write-only register bank inside the block. That state is:

- the 48-bit station address, split over two 32-bit words;
- a maximum-length word;
- a drop-control word;
- a keep-control word, which marks a class as "don't care" and so overrides drop.

A surrounding register file or bus adapter writes these words through a one-cycle write strobe with a select code. The receive datapath presents one destination per `dst_valid` pulse.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset the station address is all zeros, the maximum length is 0x0600, the drop word is 0, and the keep word is 0x3FFFF (both keep bits 9 and 8 set).
- R2: `dec_valid` is high exactly in the cycle after each cycle in which `dst_valid` is high, and low otherwise.
- R3: A frame whose `frame_len` is greater than bits [15:0] of the maximum-length word is dropped, whatever its destination. A frame whose length equals the limit passes the length test.
- R4: Station word high (select 0) holds octets 1, 2, 3 and 4 in bits [31:24], [23:16], [15:8] and [7:0]. Station word low (select 1) holds octet 5 in [31:24] and octet 6 in [23:16]; its bits [15:0] are ignored. On `dst_addr`, octet 1 is bits [47:40] and octet 6 is bits [7:0].
- R5: An all-ones destination is accepted when keep bit 9 is set. Otherwise it is dropped when drop bit 9 is set, and it is accepted in all other cases.
- R6: A destination that is not all-ones, with bit 0 of octet 1 (`dst_addr[40]`) set, is multicast. It follows the same rule as R5, using bit 8 of the keep word and bit 8 of the drop word.
- R7: Broadcast classification takes priority over multicast. An all-ones destination is never subject to the bit-8 controls.
- R8: Any other destination is accepted only when all six octets equal the station address.
- R9: Register selects are 0 (station high), 1 (station low), 2 (maximum length), 3 (drop word) and 4 (keep word). A write with any other select changes no filter state. A write takes effect for destinations presented in later cycles.
- R10: `dec_class` reports 2'b00 for unicast, 2'b01 for multicast and 2'b10 for broadcast, alongside `dec_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select code (R9) |
| reg_wr_data | input | 32 | Register write data |
| dst_valid | input | 1 | Destination and length are presented this cycle |
| dst_addr | input | 48 | Destination address, octet 1 in bits [47:40] |
| frame_len | input | 16 | Frame length in bytes |
| dec_valid | output | 1 | Decision strobe, one cycle after `dst_valid` |
| dec_accept | output | 1 | 1 = accept frame, 0 = drop |
| dec_class | output | 2 | Destination class (R10) |

## Verification
The properties compare the decision with the filter state sampled at the same edge as `dst_valid`. They therefore assume that a register write and a destination strobe sharing a cycle are judged against the old state. The bench keeps register writes and destination strobes in separate cycles, so its reference model never has to resolve such an overlap.

The random destinations are weighted so that every class reaches the filter often:
- broadcast;
- multicast;
- an exact station match;
- a station address with one octet changed;
- random unicast.

Lengths are drawn around the current limit. Control words are rewritten at random intervals so that every keep/drop combination is crossed with every class.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    CLS_UNICAST   = 2'b00,
    CLS_MULTICAST = 2'b01,
    CLS_BROADCAST = 2'b10
  } dest_class_e;

  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_STA_HI = 3'd0;
  localparam logic [SEL_W-1:0] SEL_STA_LO = 3'd1;
  localparam logic [SEL_W-1:0] SEL_MAXLEN = 3'd2;
  localparam logic [SEL_W-1:0] SEL_DROP   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_KEEP   = 3'd4;
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          LEN_W    = 16,
  parameter int          OCTETS   = 6,
  parameter int          BC_BIT   = 9,
  parameter int          MC_BIT   = 8,
  parameter logic [31:0] LEN_RST  = 32'h0000_0600,
  parameter logic [31:0] KEEP_RST = 32'h0003_FFFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [8*OCTETS-1:0]   station,
  output logic [LEN_W-1:0]      max_len,
  output logic                  drop_bc,
  output logic                  drop_mc,
  output logic                  keep_bc,
  output logic                  keep_mc
);
  localparam int ADDR_W = 8 * OCTETS;
  localparam int LO_W   = ADDR_W - DATA_W;

  logic [DATA_W-1:0] sta_hi_q, sta_hi_d;
  logic [LO_W-1:0]   sta_lo_q, sta_lo_d;
  logic [LEN_W-1:0]  max_q, max_d;
  logic              dbc_q, dbc_d, dmc_q, dmc_d;
  logic              kbc_q, kbc_d, kmc_q, kmc_d;

  always_comb begin
    sta_hi_d = sta_hi_q;
    sta_lo_d = sta_lo_q;
    max_d    = max_q;
    dbc_d    = dbc_q;
    dmc_d    = dmc_q;
    kbc_d    = kbc_q;
    kmc_d    = kmc_q;
    case (wr_sel)
      SEL_STA_HI: sta_hi_d = wr_data;
      SEL_STA_LO: sta_lo_d = wr_data[DATA_W-1 -: LO_W];
      SEL_MAXLEN: max_d    = wr_data[LEN_W-1:0];
      SEL_DROP: begin
        dbc_d = wr_data[BC_BIT];
        dmc_d = wr_data[MC_BIT];
      end
      SEL_KEEP: begin
        kbc_d = wr_data[BC_BIT];
        kmc_d = wr_data[MC_BIT];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_hi_q <= '0;
      sta_lo_q <= '0;
      max_q    <= LEN_RST[LEN_W-1:0];
      dbc_q    <= 1'b0;
      dmc_q    <= 1'b0;
      kbc_q    <= KEEP_RST[BC_BIT];
      kmc_q    <= KEEP_RST[MC_BIT];
    end else if (wr_en) begin
      sta_hi_q <= sta_hi_d;
      sta_lo_q <= sta_lo_d;
      max_q    <= max_d;
      dbc_q    <= dbc_d;
      dmc_q    <= dmc_d;
      kbc_q    <= kbc_d;
      kmc_q    <= kmc_d;
    end
  end

  assign station = {sta_hi_q, sta_lo_q};
  assign max_len = max_q;
  assign drop_bc = dbc_q;
  assign drop_mc = dmc_q;
  assign keep_bc = kbc_q;
  assign keep_mc = kmc_q;
endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
#(
  parameter int OCTETS = 6,
  parameter int LEN_W  = 16
) (
  input  logic [8*OCTETS-1:0] dst_addr,
  input  logic [8*OCTETS-1:0] station,
  input  logic [LEN_W-1:0]    frame_len,
  input  logic [LEN_W-1:0]    max_len,
  input  logic                drop_bc,
  input  logic                drop_mc,
  input  logic                keep_bc,
  input  logic                keep_mc,
  output logic                accept,
  output dest_class_e         cls
);
  localparam int ADDR_W = 8 * OCTETS;

  logic [OCTETS-1:0] oct_hit;
  logic [OCTETS-1:0] oct_ones;

  for (genvar i = 0; i < OCTETS; i++) begin : g_octet
    assign oct_hit[i]  = (dst_addr[8*i +: 8] == station[8*i +: 8]);
    assign oct_ones[i] = &dst_addr[8*i +: 8];
  end

  logic is_bc, is_mc, uc_hit, len_ok, bc_pass, mc_pass, addr_ok;

  assign is_bc   = &oct_ones;
  assign is_mc   = dst_addr[ADDR_W-8] & ~is_bc;
  assign uc_hit  = &oct_hit;
  assign len_ok  = (frame_len <= max_len);
  assign bc_pass = keep_bc | ~drop_bc;
  assign mc_pass = keep_mc | ~drop_mc;

  always_comb begin
    if (is_bc) begin
      cls     = CLS_BROADCAST;
      addr_ok = bc_pass;
    end else if (is_mc) begin
      cls     = CLS_MULTICAST;
      addr_ok = mc_pass;
    end else begin
      cls     = CLS_UNICAST;
      addr_ok = uc_hit;
    end
    accept = addr_ok & len_ok;
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int OCTETS = 6,
  parameter int BC_BIT = 9,
  parameter int MC_BIT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [2:0]          reg_wr_sel,
  input  logic [DATA_W-1:0]   reg_wr_data,
  input  logic                dst_valid,
  input  logic [8*OCTETS-1:0] dst_addr,
  input  logic [LEN_W-1:0]    frame_len,
  output logic                dec_valid,
  output logic                dec_accept,
  output logic [1:0]          dec_class
);
  localparam int ADDR_W = 8 * OCTETS;

  logic [ADDR_W-1:0] cur_station;
  logic [LEN_W-1:0]  cur_max_len;
  logic              cur_drop_bc, cur_drop_mc, cur_keep_bc, cur_keep_mc;
  logic              cmb_accept;
  dest_class_e       cmb_class;

  rxf_regs #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .OCTETS(OCTETS),
    .BC_BIT(BC_BIT), .MC_BIT(MC_BIT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_sel  (reg_wr_sel),
    .wr_data (reg_wr_data),
    .station (cur_station),
    .max_len (cur_max_len),
    .drop_bc (cur_drop_bc),
    .drop_mc (cur_drop_mc),
    .keep_bc (cur_keep_bc),
    .keep_mc (cur_keep_mc)
  );

  rxf_classify #(.OCTETS(OCTETS), .LEN_W(LEN_W)) u_cls (
    .dst_addr  (dst_addr),
    .station   (cur_station),
    .frame_len (frame_len),
    .max_len   (cur_max_len),
    .drop_bc   (cur_drop_bc),
    .drop_mc   (cur_drop_mc),
    .keep_bc   (cur_keep_bc),
    .keep_mc   (cur_keep_mc),
    .accept    (cmb_accept),
    .cls       (cmb_class)
  );

  logic        vld_q, vld_d;
  logic        acc_q, acc_d;
  dest_class_e cls_q, cls_d;

  always_comb begin
    vld_d = dst_valid;
    acc_d = cmb_accept;
    cls_d = cmb_class;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      cls_q <= CLS_UNICAST;
    end else if (dst_valid) begin
      acc_q <= acc_d;
      cls_q <= cls_d;
    end
  end

  assign dec_valid  = vld_q;
  assign dec_accept = acc_q;
  assign dec_class  = cls_q;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dst_valid,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [LEN_W-1:0]  frame_len,
  input logic [ADDR_W-1:0] station,
  input logic [LEN_W-1:0]  max_len,
  input logic              drop_mc,
  input logic              keep_bc,
  input logic              keep_mc,
  input logic              dec_valid,
  input logic              dec_accept,
  input logic [1:0]        dec_class
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> dec_valid);

  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_valid |=> !dec_valid);

  p_oversize_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && frame_len > max_len) |=> !dec_accept);

  p_bcast_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && (&dst_addr) && keep_bc && frame_len <= max_len)
      |=> (dec_accept && dec_class == 2'b10));

  p_mcast_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && dst_addr[ADDR_W-8] && !(&dst_addr) && !keep_mc && drop_mc)
      |=> (!dec_accept && dec_class == 2'b01));

  p_ucast_mismatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_addr[ADDR_W-8] && dst_addr != station)
      |=> (!dec_accept && dec_class == 2'b00));
endmodule

bind rx_dest_filter rxf_checker #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_rxf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .dst_valid  (dst_valid),
  .dst_addr   (dst_addr),
  .frame_len  (frame_len),
  .station    (cur_station),
  .max_len    (cur_max_len),
  .drop_mc    (cur_drop_mc),
  .keep_bc    (cur_keep_bc),
  .keep_mc    (cur_keep_mc),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept),
  .dec_class  (dec_class)
);

// File: tb/test_rx_dest_filter.sv
`timescale 1ns/1ps
module test_rx_dest_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [2:0]  reg_wr_sel;
  logic [31:0] reg_wr_data;
  logic        dst_valid;
  logic [47:0] dst_addr;
  logic [15:0] frame_len;
  logic        dec_valid;
  logic        dec_accept;
  logic [1:0]  dec_class;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Shadow of the filter state, kept from the requirements
  logic [31:0] m_hi;
  logic [15:0] m_lo;
  logic [15:0] m_max;
  logic        m_dbc, m_dmc, m_kbc, m_kmc;

  always #5 clk = ~clk;

  rx_dest_filter i_rx_dest_filter (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .dst_valid(dst_valid), .dst_addr(dst_addr), .frame_len(frame_len),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_class(dec_class)
  );

  function automatic logic [2:0] ref_decide(input logic [47:0] a, input logic [15:0] l);
    logic [1:0] c;
    logic ok;
    if (a == 48'hFFFF_FFFF_FFFF) begin
      c = 2'b10; ok = m_kbc | ~m_dbc;
    end else if (a[40]) begin
      c = 2'b01; ok = m_kmc | ~m_dmc;
    end else begin
      c = 2'b00; ok = (a == {m_hi, m_lo});
    end
    return {ok & (l <= m_max), c};
  endfunction

  task automatic check(input bit cond, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
    case (sel)
      3'd0: m_hi = data;
      3'd1: m_lo = data[31:16];
      3'd2: m_max = data[15:0];
      3'd3: begin m_dbc = data[9]; m_dmc = data[8]; end
      3'd4: begin m_kbc = data[9]; m_kmc = data[8]; end
      default: ;
    endcase
  endtask

  task automatic send(input logic [47:0] a, input logic [15:0] l, input string req);
    logic [2:0] e;
    e = ref_decide(a, l);
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = a; frame_len = l;
    @(negedge clk);
    dst_valid = 1'b0;
    check(dec_valid == 1'b1 && dec_accept == e[2] && dec_class == e[1:0], req,
          "valid/accept/class", {dec_valid, dec_accept, dec_class}, {1'b1, e});
    @(negedge clk);
    check(dec_valid == 1'b0, "R2", "valid one cycle only", dec_valid, 0);
  endtask

  function automatic logic [47:0] rnd48();
    return {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr_en = 0; reg_wr_sel = 0; reg_wr_data = 0;
    dst_valid = 0; dst_addr = 0; frame_len = 0;
    m_hi = 0; m_lo = 0; m_max = 16'h0600;
    m_dbc = 0; m_dmc = 0; m_kbc = 1; m_kmc = 1;
    repeat (3) @(negedge clk);
    check(dec_valid == 1'b0, "R1", "valid in reset", dec_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dec_valid == 1'b0, "R2", "valid idle after reset", dec_valid, 0);

    // R1 reset state
    send(48'hFFFF_FFFF_FFFF, 16'h0600, "R1 bcast at reset limit");
    send(48'hFFFF_FFFF_FFFF, 16'h0601, "R1 R3 over reset limit");
    send(48'h0, 16'd64, "R1 station zero");
    send(48'h0100_5E00_0001, 16'd64, "R1 mcast keep set");

    // R4 station layout
    wr(3'd0, 32'h0211_2233);
    wr(3'd1, 32'h4455_ABCD);
    send(48'h0211_2233_4455, 16'd100, "R4 R8 exact match");
    send(48'h0211_2233_4454, 16'd100, "R8 octet6 differs");
    send(48'h0611_2233_4455, 16'd100, "R8 octet1 differs");
    send(48'h0211_2233_0000, 16'd100, "R4 low bits ignored");

    // R5 R6 R7 policy
    wr(3'd4, 32'h0);
    wr(3'd3, 32'h300);
    send(48'hFFFF_FFFF_FFFF, 16'd64, "R5 bcast drop");
    send(48'h3300_0000_0001, 16'd64, "R6 mcast drop");
    wr(3'd3, 32'h100);
    send(48'hFFFF_FFFF_FFFF, 16'd64, "R7 bcast ignores bit8");
    send(48'h0100_5E7F_FFFA, 16'd64, "R6 mcast drop bit8");
    wr(3'd3, 32'h200);
    send(48'h0100_5E7F_FFFA, 16'd64, "R6 mcast pass");
    send(48'hFFFF_FFFF_FFFF, 16'd64, "R5 bcast drop bit9");
    wr(3'd4, 32'h200);
    wr(3'd3, 32'h300);
    send(48'hFFFF_FFFF_FFFF, 16'd64, "R5 keep overrides drop");
    send(48'hFFFF_FFFF_FFFE, 16'd64, "R10 R6 near-broadcast is mcast");
    send(48'hFEFF_FFFF_FFFF, 16'd64, "R10 R8 near-broadcast unicast");

    // R3 length limit uses low 16 bits
    wr(3'd2, 32'hABCD_0040);
    send(48'h0211_2233_4455, 16'h0040, "R3 equal limit");
    send(48'h0211_2233_4455, 16'h0041, "R3 one over limit");
    send(48'hFFFF_FFFF_FFFF, 16'hFFFF, "R3 oversize bcast");

    // R9 unlisted selects change nothing
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'h0);
    wr(3'd7, 32'h0000_0000);
    send(48'h0211_2233_4455, 16'h0040, "R9 station kept");
    send(48'h0211_2233_4455, 16'h0041, "R9 limit kept");
    send(48'hFFFF_FFFF_FFFF, 16'd10, "R9 keep kept");
    send(48'h0100_0000_0000, 16'd10, "R9 drop kept");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [47:0] a;
      logic [15:0] l;
      int k;
      if (n % 25 == 0) begin
        wr(3'd3, $urandom & 32'h300);
        wr(3'd4, $urandom & 32'h300);
        wr(3'd2, {16'h0, 16'd60 + 16'($urandom_range(0, 1500))});
        if (n % 100 == 0) begin
          wr(3'd0, $urandom & 32'hFEFF_FFFF);
          wr(3'd1, $urandom);
        end
      end
      k = $urandom_range(0, 4);
      case (k)
        0: a = 48'hFFFF_FFFF_FFFF;
        1: a = rnd48() | 48'h0100_0000_0000;
        2: a = {m_hi, m_lo};
        3: a = {m_hi, m_lo} ^ (48'h1 << (8 * $urandom_range(0, 5) + $urandom_range(1, 7)));
        default: a = rnd48() & 48'hFEFF_FFFF_FFFF;
      endcase
      l = m_max + 16'($urandom_range(0, 4)) - 16'd2;
      send(a, l, "R3 R5 R6 R8 R10 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule